// File: doc/BRIEF.md
# Slot Hotplug Controller

This block tracks device insertion and removal across a row of expansion slots and presents the result to software through a small window of 32-bit registers. It keeps three slot bitmaps: devices present, removals requested and not yet acknowledged, and slots able to accept hot insertion. Platform logic reports each event through per-slot strobes. A hot insertion or a removal request raises a general-purpose event status bit, which drives an interrupt when enabled.

Software reads the "inserted" view, which is computed as present AND capable. This means every capable slot that holds a device can be checked again. Extra checks of that kind are harmless. Software acknowledges a removal by writing a slot mask to the eject register, and only the lowest set bit of that mask is used. A platform reset input starts a rebuild sequence. It first executes every outstanding removal, lowest slot first, one per cycle. It then reloads the capable bitmap from the platform's capability mask. Devices that survive the sequence stay present.

Top module: `hpc_slot_ctrl`

## Requirements
- R1: A read at offset 0x00 returns the present bitmap ANDed with the capable bitmap.
- R2: A read at offset 0x04 returns the pending-removal bitmap. A remove-request strobe on slot n sets bit n of that bitmap.
- R3: A read at offset 0x0C returns the capable bitmap. That bitmap is loaded from `cap_mask_i` only at the end of a rebuild sequence and ignores `cap_mask_i` at all other times.
- R4: A write at offset 0x08 selects slot n, where n is the index of the lowest set bit of the written word. The write clears bit n of the pending bitmap. It clears present bit n only when slot n is capable. The higher bits of the written word are ignored.
- R5: A write of zero at offset 0x08 changes nothing. A read at offset 0x08 returns zero.
- R6: An insert strobe with `coldplug_i` low sets the slot's present bit and sets event status bit 1. A remove-request strobe also sets event status bit 1.
- R7: An insert strobe with `coldplug_i` high sets the present bit and leaves the event status unchanged.
- R8: Event status bit 1 appears at offset 0x10 and is cleared by writing 1 to bit 1 there. A new event in the same cycle wins over the clear. Event enable bit 1 appears at offset 0x14 and can be read and written. `irq_o` is high exactly when both bits are set. All other bits of both registers read zero.
- R9: When an eject write and an insert strobe hit the same slot in one cycle, the slot ends present. When an eject write and a remove-request strobe hit the same slot in one cycle, the slot ends pending.
- R10: A pulse on `sys_rst_i` starts a rebuild sequence. The sequence applies the R4 eject rule to each pending slot, lowest first and one per cycle, and then loads the capable bitmap. Strobes and eject writes are ignored in the pulse cycle and during the sequence. The event registers are left alone. The sequence ends within NUM_SLOTS+2 cycles.
- R11: While `rst_ni` is low, the present, pending, capable, status and enable state is all zero. The capable bitmap is loaded on the first clock edge after release.
- R12: Writes to offsets 0x00, 0x04, 0x0C and to unmapped offsets change nothing. Reads of unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sys_rst_i | input | 1 | Platform reset pulse; starts the rebuild sequence |
| cap_mask_i | input | NUM_SLOTS | Per-slot capability (1 = hotplug-capable) |
| ins_i | input | NUM_SLOTS | Per-slot insert strobe |
| coldplug_i | input | 1 | Marks this cycle's insert strobes as boot-time insertions |
| rmv_i | input | NUM_SLOTS | Per-slot removal-request strobe |
| addr_i | input | ADDR_W | Register byte offset |
| we_i | input | 1 | Write strobe |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data for `addr_i` (combinational) |
| irq_o | output | 1 | Event interrupt |

## Verification
The bench builds the block with 32 slots, a 32-bit data path and the ripple variant of the lowest-bit finder. Because of this, slot 31 and eject words whose only set bit is bit 31 exercise the top end of both the finder chain and the bitmaps. A capability mask with holes makes non-capable slots reachable. Their hidden present bits become visible once a rebuild loads an all-ones mask. Random stimulus overlaps strobes with eject writes, so same-slot collisions occur alongside the directed cases.

// File: rtl/hpc_pkg.sv
`timescale 1ns/1ps
package hpc_pkg;

   typedef enum logic [0:0] {
      PH_DRAIN = 1'b0,
      PH_RUN   = 1'b1
   } hpc_phase_e;

   localparam int unsigned OFF_INSERTED = 32'h00;
   localparam int unsigned OFF_PENDING  = 32'h04;
   localparam int unsigned OFF_EJECT    = 32'h08;
   localparam int unsigned OFF_CAPABLE  = 32'h0C;
   localparam int unsigned OFF_EVT_STS  = 32'h10;
   localparam int unsigned OFF_EVT_EN   = 32'h14;

   localparam int unsigned MIN_ADDR_W   = 5;

endpackage

// File: rtl/hpc_lowbit.sv
`timescale 1ns/1ps
module hpc_lowbit #(
   parameter int unsigned W     = 32,
   parameter bit          ARITH = 1'b1
) (
   input  logic [W-1:0] vec_i,
   output logic [W-1:0] onehot_o,
   output logic         found_o
);

   if (W < 1) begin : g_bad_w
      $error("hpc_lowbit: W must be at least 1");
   end

   if (ARITH) begin : g_arith
      // two's complement isolates the lowest set bit
      assign onehot_o = vec_i & (~vec_i + 1'b1);
      assign found_o  = |vec_i;
   end else begin : g_ripple
      logic [W-1:0] seen;
      for (genvar i = 0; i < W; i++) begin : g_bit
         if (i == 0) begin : g_first
            assign onehot_o[i] = vec_i[i];
            assign seen[i]     = vec_i[i];
         end else begin : g_rest
            assign onehot_o[i] = vec_i[i] & ~seen[i-1];
            assign seen[i]     = seen[i-1] | vec_i[i];
         end
      end
      assign found_o = seen[W-1];
   end

endmodule

// File: rtl/hpc_slot_state.sv
`timescale 1ns/1ps
module hpc_slot_state
   import hpc_pkg::*;
#(
   parameter int unsigned NUM_SLOTS = 32,
   parameter bit          ARITH     = 1'b1
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 sys_rst_i,
   input  logic [NUM_SLOTS-1:0] cap_mask_i,
   input  logic [NUM_SLOTS-1:0] ins_i,
   input  logic [NUM_SLOTS-1:0] rmv_i,
   input  logic                 ej_we_i,
   input  logic [NUM_SLOTS-1:0] ej_sel_i,
   output logic [NUM_SLOTS-1:0] present_o,
   output logic [NUM_SLOTS-1:0] pending_o,
   output logic [NUM_SLOTS-1:0] capable_o,
   output logic                 run_o
);

   hpc_phase_e           phase_q;
   logic [NUM_SLOTS-1:0] present_q, pending_q, cap_q;
   logic [NUM_SLOTS-1:0] present_d, pending_d;
   logic [NUM_SLOTS-1:0] drain_sel, sel, ins_eff, rmv_eff;
   logic                 drain_found;
   logic                 run, draining, drain_done;

   hpc_lowbit #(.W(NUM_SLOTS), .ARITH(ARITH)) u_drain_pick (
      .vec_i    (pending_q),
      .onehot_o (drain_sel),
      .found_o  (drain_found)
   );

   assign run        = (phase_q == PH_RUN) && !sys_rst_i;
   assign draining   = (phase_q == PH_DRAIN);
   assign drain_done = draining && !drain_found;

   always_comb begin
      sel     = '0;
      ins_eff = '0;
      rmv_eff = '0;
      if (run) begin
         ins_eff = ins_i;
         rmv_eff = rmv_i;
         if (ej_we_i) sel = ej_sel_i;
      end else if (draining) begin
         sel = drain_sel;
      end
   end

   // eject applied first, then insert / remove request
   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      assign present_d[s] = (present_q[s] & ~(sel[s] & cap_q[s])) | ins_eff[s];
      assign pending_d[s] = (pending_q[s] & ~sel[s]) | rmv_eff[s];
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         phase_q   <= PH_DRAIN;
         present_q <= '0;
         pending_q <= '0;
         cap_q     <= '0;
      end else begin
         present_q <= present_d;
         pending_q <= pending_d;
         if (drain_done) begin
            cap_q   <= cap_mask_i;
            phase_q <= PH_RUN;
         end else if ((phase_q == PH_RUN) && sys_rst_i) begin
            phase_q <= PH_DRAIN;
         end
      end
   end

   assign present_o = present_q;
   assign pending_o = pending_q;
   assign capable_o = cap_q;
   assign run_o     = run;

   // R4: an eject clears the selected pending bit unless re-requested
   a_r4_eject_clears_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run && ej_we_i && (ej_sel_i != '0) && ((ej_sel_i & rmv_i) == '0))
      |=> ((pending_q & $past(ej_sel_i)) == '0));

   // R4: a non-capable slot never loses its present bit
   a_r4_fixed_slot_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (phase_q == PH_RUN)
      |=> (($past(present_q) & ~$past(cap_q) & ~present_q) == '0));

   // R10: each drain cycle retires exactly one pending slot
   a_r10_drain_one_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (draining && (pending_q != '0))
      |=> ($countones(pending_q) + 1 == $countones($past(pending_q))));

   // R10: no slot becomes present while draining
   a_r10_drain_no_insert: assert property (@(posedge clk_i) disable iff (!rst_ni)
      draining |=> ((present_q & ~$past(present_q)) == '0));

   // R3: the capable bitmap is frozen during normal operation
   a_r3_cap_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (phase_q == PH_RUN) |=> $stable(cap_q));

endmodule

// File: rtl/hpc_event.sv
`timescale 1ns/1ps
module hpc_event (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic hot_evt_i,
   input  logic sts_we_i,
   input  logic en_we_i,
   input  logic wbit_i,
   output logic sts_o,
   output logic en_o,
   output logic irq_o
);

   logic sts_q, en_q;
   logic clr;

   assign clr = sts_we_i && wbit_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sts_q <= 1'b0;
         en_q  <= 1'b0;
      end else begin
         if (hot_evt_i)   sts_q <= 1'b1;
         else if (clr)    sts_q <= 1'b0;
         if (en_we_i)     en_q  <= wbit_i;
      end
   end

   assign sts_o = sts_q;
   assign en_o  = en_q;
   assign irq_o = sts_q & en_q;

   // R8: a new event wins over a same-cycle clear
   a_r8_event_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hot_evt_i |=> sts_q);

   // R8: write-1-to-clear without a competing event clears
   a_r8_w1c_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr && !hot_evt_i) |=> !sts_q);

   // R7, R8: status only moves on an event or a clear
   a_r8_status_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!hot_evt_i && !clr) |=> $stable(sts_q));

endmodule

// File: rtl/hpc_bus_decode.sv
`timescale 1ns/1ps
module hpc_bus_decode
   import hpc_pkg::*;
#(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned NUM_SLOTS = 32,
   parameter int unsigned EVT_BIT   = 1
) (
   input  logic [ADDR_W-1:0]    addr_i,
   input  logic                 we_i,
   input  logic [NUM_SLOTS-1:0] present_i,
   input  logic [NUM_SLOTS-1:0] pending_i,
   input  logic [NUM_SLOTS-1:0] capable_i,
   input  logic                 sts_i,
   input  logic                 en_i,
   output logic [DATA_W-1:0]    rdata_o,
   output logic                 ej_we_o,
   output logic                 sts_we_o,
   output logic                 en_we_o
);

   localparam logic [ADDR_W-1:0] A_INS = ADDR_W'(OFF_INSERTED);
   localparam logic [ADDR_W-1:0] A_PND = ADDR_W'(OFF_PENDING);
   localparam logic [ADDR_W-1:0] A_EJ  = ADDR_W'(OFF_EJECT);
   localparam logic [ADDR_W-1:0] A_CAP = ADDR_W'(OFF_CAPABLE);
   localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(OFF_EVT_STS);
   localparam logic [ADDR_W-1:0] A_EN  = ADDR_W'(OFF_EVT_EN);

   logic [DATA_W-1:0] ins_w, pnd_w, cap_w, sts_w, en_w;

   if (NUM_SLOTS == DATA_W) begin : g_full
      assign ins_w = present_i & capable_i;
      assign pnd_w = pending_i;
      assign cap_w = capable_i;
   end else begin : g_pad
      localparam int unsigned PAD = DATA_W - NUM_SLOTS;
      assign ins_w = {{PAD{1'b0}}, present_i & capable_i};
      assign pnd_w = {{PAD{1'b0}}, pending_i};
      assign cap_w = {{PAD{1'b0}}, capable_i};
   end

   always_comb begin
      sts_w          = '0;
      en_w           = '0;
      sts_w[EVT_BIT] = sts_i;
      en_w[EVT_BIT]  = en_i;
   end

   always_comb begin
      unique case (addr_i)
         A_INS:   rdata_o = ins_w;
         A_PND:   rdata_o = pnd_w;
         A_CAP:   rdata_o = cap_w;
         A_STS:   rdata_o = sts_w;
         A_EN:    rdata_o = en_w;
         default: rdata_o = '0;
      endcase
   end

   assign ej_we_o  = we_i && (addr_i == A_EJ);
   assign sts_we_o = we_i && (addr_i == A_STS);
   assign en_we_o  = we_i && (addr_i == A_EN);

endmodule

// File: rtl/hpc_slot_ctrl.sv
`timescale 1ns/1ps
module hpc_slot_ctrl
   import hpc_pkg::*;
#(
   parameter int unsigned NUM_SLOTS   = 32,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned EVT_BIT     = 1,
   parameter bit          LOWBIT_ARITH = 1'b1
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 sys_rst_i,
   input  logic [NUM_SLOTS-1:0] cap_mask_i,
   input  logic [NUM_SLOTS-1:0] ins_i,
   input  logic                 coldplug_i,
   input  logic [NUM_SLOTS-1:0] rmv_i,
   input  logic [ADDR_W-1:0]    addr_i,
   input  logic                 we_i,
   input  logic [DATA_W-1:0]    wdata_i,
   output logic [DATA_W-1:0]    rdata_o,
   output logic                 irq_o
);

   if (NUM_SLOTS < 1 || NUM_SLOTS > DATA_W) begin : g_bad_slots
      $error("hpc_slot_ctrl: NUM_SLOTS must be 1..DATA_W");
   end
   if (EVT_BIT >= DATA_W) begin : g_bad_evt
      $error("hpc_slot_ctrl: EVT_BIT outside data word");
   end
   if (ADDR_W < MIN_ADDR_W) begin : g_bad_addr
      $error("hpc_slot_ctrl: ADDR_W too narrow for register window");
   end

   logic [DATA_W-1:0]    ej_onehot;
   logic                 ej_found;
   logic                 ej_we, sts_we, en_we;
   logic [NUM_SLOTS-1:0] present, pending, capable;
   logic                 run, sts, en, hot_evt;

   hpc_lowbit #(.W(DATA_W), .ARITH(LOWBIT_ARITH)) u_ej_pick (
      .vec_i    (wdata_i),
      .onehot_o (ej_onehot),
      .found_o  (ej_found)
   );

   hpc_bus_decode #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .NUM_SLOTS (NUM_SLOTS),
      .EVT_BIT   (EVT_BIT)
   ) u_decode (
      .addr_i    (addr_i),
      .we_i      (we_i),
      .present_i (present),
      .pending_i (pending),
      .capable_i (capable),
      .sts_i     (sts),
      .en_i      (en),
      .rdata_o   (rdata_o),
      .ej_we_o   (ej_we),
      .sts_we_o  (sts_we),
      .en_we_o   (en_we)
   );

   hpc_slot_state #(.NUM_SLOTS(NUM_SLOTS), .ARITH(LOWBIT_ARITH)) u_state (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .sys_rst_i  (sys_rst_i),
      .cap_mask_i (cap_mask_i),
      .ins_i      (ins_i),
      .rmv_i      (rmv_i),
      .ej_we_i    (ej_we && ej_found),
      .ej_sel_i   (ej_onehot[NUM_SLOTS-1:0]),
      .present_o  (present),
      .pending_o  (pending),
      .capable_o  (capable),
      .run_o      (run)
   );

   assign hot_evt = run && (((ins_i != '0) && !coldplug_i) || (rmv_i != '0));

   hpc_event u_event (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .hot_evt_i (hot_evt),
      .sts_we_i  (sts_we),
      .en_we_i   (en_we),
      .wbit_i    (wdata_i[EVT_BIT]),
      .sts_o     (sts),
      .en_o      (en),
      .irq_o     (irq_o)
   );

   // R9: an insert strobe always leaves the slot present next cycle
   a_r9_insert_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run && (ins_i != '0)) |=> ((present & $past(ins_i)) == $past(ins_i)));

endmodule

// File: tb/hpc_slot_ctrl_bench.sv
`timescale 1ns/1ps
module hpc_slot_ctrl_bench;

   localparam int unsigned NS = 32;
   localparam int unsigned DW = 32;
   localparam int unsigned AW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sys_rst = 1'b0;
   logic [NS-1:0] cap_in = '0;
   logic [NS-1:0] ins = '0;
   logic          cold = 1'b0;
   logic [NS-1:0] rmv = '0;
   logic [AW-1:0] addr = '0;
   logic          we = 1'b0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic          irq;

   int unsigned n_checks = 0;
   int unsigned n_fail = 0;
   bit          done = 1'b0;

   logic [31:0] m_pres = '0, m_pend = '0, m_cap = '0;
   bit          m_sts = 1'b0, m_en = 1'b0;

   always #4 clk = ~clk;

   hpc_slot_ctrl #(
      .NUM_SLOTS    (NS),
      .DATA_W       (DW),
      .ADDR_W       (AW),
      .EVT_BIT      (1),
      .LOWBIT_ARITH (1'b0)
   ) u_hpc_slot_ctrl (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .sys_rst_i  (sys_rst),
      .cap_mask_i (cap_in),
      .ins_i      (ins),
      .coldplug_i (cold),
      .rmv_i      (rmv),
      .addr_i     (addr),
      .we_i       (we),
      .wdata_i    (wdata),
      .rdata_o    (rdata),
      .irq_o      (irq)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_read(input logic [7:0] a);
      case (a)
         8'h00:   return m_pres & m_cap;
         8'h04:   return m_pend;
         8'h0C:   return m_cap;
         8'h10:   return {30'd0, m_sts, 1'b0};
         8'h14:   return {30'd0, m_en, 1'b0};
         default: return 32'h0;
      endcase
   endfunction

   function automatic void model_step(input logic [31:0] i_ins, input bit i_cold,
                                      input logic [31:0] i_rmv, input bit i_we,
                                      input logic [7:0] i_addr, input logic [31:0] i_wd);
      logic [31:0] low;
      low = '0;
      if (i_we && i_addr == 8'h08) low = i_wd & (~i_wd + 32'd1);
      m_pres = (m_pres & ~(low & m_cap)) | i_ins;
      m_pend = (m_pend & ~low) | i_rmv;
      if ((i_ins != 0 && !i_cold) || i_rmv != 0) m_sts = 1'b1;
      else if (i_we && i_addr == 8'h10 && i_wd[1]) m_sts = 1'b0;
      if (i_we && i_addr == 8'h14) m_en = i_wd[1];
   endfunction

   task automatic op(input logic [31:0] i_ins, input bit i_cold, input logic [31:0] i_rmv,
                     input bit i_we, input logic [7:0] i_addr, input logic [31:0] i_wd);
      @(negedge clk);
      ins = i_ins; cold = i_cold; rmv = i_rmv;
      we = i_we; addr = i_addr; wdata = i_wd;
      @(posedge clk);
      model_step(i_ins, i_cold, i_rmv, i_we, i_addr, i_wd);
      @(negedge clk);
      ins = '0; cold = 1'b0; rmv = '0; we = 1'b0; wdata = '0;
   endtask

   task automatic check_all(input string ctx);
      logic [7:0] offs [7];
      string      tags [7];
      offs = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h18};
      tags = '{"R1", "R2", "R5", "R3", "R8", "R8", "R12"};
      for (int k = 0; k < 7; k++) begin
         @(negedge clk);
         addr = offs[k];
         #1;
         check($sformatf("%s %s off=%h", tags[k], ctx, offs[k]), rdata, exp_read(offs[k]));
      end
      check($sformatf("R8 %s irq", ctx), {31'd0, irq}, {31'd0, m_sts & m_en});
   endtask

   // R10: platform reset pulse with strobes that must be ignored
   task automatic soft_reset(input logic [31:0] new_cap);
      logic [31:0] low;
      @(negedge clk);
      cap_in = new_cap;
      sys_rst = 1'b1;
      ins = 32'h0000_0F00; rmv = 32'h00F0_0000; cold = 1'b0;
      we = 1'b1; addr = 8'h08; wdata = 32'hFFFF_FFFF;
      @(negedge clk);
      sys_rst = 1'b0;
      @(negedge clk);
      ins = '0; rmv = '0; we = 1'b0; wdata = '0;
      repeat (NS + 2) @(negedge clk);
      while (m_pend != 0) begin
         low = m_pend & (~m_pend + 32'd1);
         m_pres = m_pres & ~(low & m_cap);
         m_pend = m_pend & ~low;
      end
      m_cap = new_cap;
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1'b1;
         $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 8);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
   end

   initial begin
      logic [31:0] cap_a;
      void'($urandom(32'd20240611));
      cap_a = ~(32'h0000_0220);          // slots 5 and 9 not hotplug-capable
      cap_in = cap_a;

      // R11: reset state
      repeat (3) @(negedge clk);
      addr = 8'h0C; #1; check("R11 cap in reset", rdata, 32'h0);
      addr = 8'h04; #1; check("R11 pend in reset", rdata, 32'h0);
      check("R11 irq in reset", {31'd0, irq}, 32'h0);
      rst_n = 1'b1;
      m_cap = cap_a;
      repeat (2) @(negedge clk);
      check_all("R11 after release");

      // R7: coldplug insert, no event
      op(32'h0000_0228, 1'b1, 32'h0, 1'b0, 8'h00, 32'h0);
      check_all("R7 coldplug");

      // R6: hot insert on slot 31 raises status
      op(32'h8000_0000, 1'b0, 32'h0, 1'b0, 8'h00, 32'h0);
      check_all("R6 hot insert");

      // R8: enable then write-1-to-clear
      op(32'h0, 1'b0, 32'h0, 1'b1, 8'h14, 32'h0000_0002);
      check_all("R8 enable");
      op(32'h0, 1'b0, 32'h0, 1'b1, 8'h10, 32'hFFFF_FFFD);
      check_all("R8 clear with bit1 low");
      op(32'h0, 1'b0, 32'h0, 1'b1, 8'h10, 32'h0000_0002);
      check_all("R8 w1c");

      // R2, R6: removal requests on slots 3, 5, 9, 31
      op(32'h0, 1'b0, 32'h8000_0228, 1'b0, 8'h00, 32'h0);
      check_all("R2 remove request");

      // R8: event and clear in same cycle, event wins
      op(32'h0, 1'b0, 32'h0000_0001, 1'b1, 8'h10, 32'h0000_0002);
      check_all("R8 set beats clear");

      // R4: multi-bit eject hits only slot 0 (lowest)
      op(32'h0, 1'b0, 32'h0, 1'b1, 8'h08, 32'h8000_0229);
      check_all("R4 lowest of many");
      // R4: eject non-capable slot 5 keeps present bit
      op(32'h0, 1'b0, 32'h0, 1'b1, 8'h08, 32'h0000_0020);
      check_all("R4 non-capable eject");
      // R4: eject slot 31 via single top bit
      op(32'h0, 1'b0, 32'h0, 1'b1, 8'h08, 32'h8000_0000);
      check_all("R4 top slot");

      // R5: zero eject changes nothing
      op(32'h0, 1'b0, 32'h0, 1'b1, 8'h08, 32'h0);
      check_all("R5 zero eject");

      // R9: eject and insert on slot 3 together -> present; eject and rmv on 9 -> pending
      op(32'h0000_0008, 1'b1, 32'h0, 1'b1, 8'h08, 32'h0000_0008);
      check_all("R9 eject+insert");
      op(32'h0, 1'b0, 32'h0000_0200, 1'b1, 8'h08, 32'h0000_0200);
      check_all("R9 eject+remove");

      // R12: writes to read-only and unmapped offsets
      op(32'h0, 1'b0, 32'h0, 1'b1, 8'h00, 32'h0);
      op(32'h0, 1'b0, 32'h0, 1'b1, 8'h04, 32'hFFFF_FFFF);
      op(32'h0, 1'b0, 32'h0, 1'b1, 8'h0C, 32'h0);
      op(32'h0, 1'b0, 32'h0, 1'b1, 8'h18, 32'hFFFF_FFFF);
      check_all("R12 ignored writes");

      // R3: cap input changes mid-run are not sampled
      cap_in = 32'h0000_FFFF;
      op(32'h0, 1'b0, 32'h0, 1'b0, 8'h00, 32'h0);
      check_all("R3 cap frozen");

      // R10: rebuild with pending 9 and 2, then reveal hidden present bits
      op(32'h0000_0004, 1'b0, 32'h0000_0004, 1'b0, 8'h00, 32'h0);
      check_all("R10 before rebuild");
      soft_reset(32'hFFFF_FFFF);
      check_all("R10 after rebuild");

      // random phase
      for (int n = 0; n < 400; n++) begin
         logic [7:0]  a;
         logic [31:0] wd, ri, rr;
         bit          w, c;
         case ($urandom % 7)
            0: a = 8'h00; 1: a = 8'h04; 2, 3: a = 8'h08;
            4: a = 8'h10; 5: a = 8'h14; default: a = 8'h18;
         endcase
         wd = (($urandom % 4) == 0) ? 32'h0 : ($urandom & $urandom);
         ri = $urandom & $urandom & $urandom & $urandom;
         rr = $urandom & $urandom & $urandom & $urandom;
         w  = $urandom % 2;
         c  = $urandom % 2;
         op(ri, c, rr, w, a, wd);
         if (n % 8 == 7) check_all("R4 random");
         if (n == 200) begin
            soft_reset($urandom);
            check_all("R10 random rebuild");
         end
      end

      finish_run();
   end

endmodule